// File: doc/BRIEF.md
# Four-Channel Buffered PWM Timer

A 16-bit timer that drives four single-slope PWM outputs from one shared counter. The counter runs up or down at a rate set by a power-of-two clock divider. It wraps once per period. A period value P gives a period of P+1 counter ticks. Each channel compares the counter against its own active compare value. The channel output is high while the counter is below that value, so a compare of 0 gives 0% duty and a compare above P gives 100% duty.

Software changes duty cycles and the period through buffer registers. While the timer runs, a buffered value moves into the active register only at the wrap point, so a waveform never changes partway through a period. Each channel also raises a sticky match flag when the counter reaches its compare value. An interrupt request combines all flags that have their mask bit set. Configuration uses a plain write strobe with an address and a 16-bit data word.

Top module: `pwm4_timer`

## Requirements
- R1: After reset the counter is 0, every flag is 0, the interrupt request is 0, every PWM output is 0, the timer is stopped and the direction is up.
- R2: Address 0 is the control word: bit 0 starts the timer, bit 1 selects the direction (1 = down), bits 4:2 select the divider, and bits 11:8 enable channels 3..0. When the timer runs upward with divider 0, the counter rises by one on every clock and goes from P to 0, which gives P+1 ticks per period.
- R3: When counting down, the counter falls by one on every tick and goes from 0 to the active period value.
- R4: While the start bit is 0, the counter keeps its value.
- R5: A divider code s makes the counter advance once every 2^s clocks. The first advance comes 2^s clocks after the start.
- R6: PWM output i is high only when channel i is enabled and the counter is below active compare i. A compare of 0 keeps the output low. A compare above the active period keeps it high for the whole period.
- R7: While the timer runs, writes to the period buffer (address 1) or to compare buffer i (address 8+i) change nothing until the next wrap tick. The wrap tick is counter = period when counting up and counter = 0 when counting down. An active value whose buffer was not written stays as it is.
- R8: While the timer is stopped, a write to the period buffer or to a compare buffer takes effect in the active register at once.
- R9: Flag i is set on any tick where the counter equals active compare i, whether or not channel i is enabled. Writing 1 to bit i at address 4 clears flag i. If a set and a clear arrive in the same cycle, the set wins.
- R10: The interrupt request is high exactly when some flag is set and its mask bit (address 3, bit i) is 1.
- R11: A write to address 2 loads the counter directly and takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm | output | 4 | PWM outputs, one per channel |
| irq | output | 1 | Interrupt request |
| flags | output | 4 | Compare-match flags |
| count | output | 16 | Current counter value |

## Verification
On every cycle the assertions check the step-by-step counter motion in both directions and the wrap from the period back to zero. They also check that the counter holds while the timer is stopped, that a flag stays set until it is cleared by a write, that a zero compare keeps an output low, and that the interrupt request never rises with no flag set. Other behaviour depends on a sequence of writes, so only the bench scenarios can show it. This covers buffered values waiting for the wrap tick in each direction, the immediate load while the timer is stopped, the divider timing, the set-over-clear case, and the full-duty compare.

// File: rtl/pwm4_timer.sv
module pwm4_timer #(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int PSW = 3,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  output logic [NCH-1:0] pwm,
  output logic           irq,
  output logic [NCH-1:0] flags,
  output logic [W-1:0]   count
);
  localparam int PRW    = (1 << PSW) - 1;
  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_CNT  = 2;
  localparam int A_MSK  = 3;
  localparam int A_CLR  = 4;
  localparam int A_CMP  = 8;
  localparam int CH_LSB = 8;

  logic                   en, dir;
  logic [PSW-1:0]         psel;
  logic [NCH-1:0]         ch_en, msk, flg;
  logic [W-1:0]           cnt, per_act, per_buf;
  logic                   per_bv;
  logic [NCH-1:0][W-1:0]  cmp_act, cmp_buf;
  logic [NCH-1:0]         cmp_bv;
  logic [PRW-1:0]         pre, pmask;
  logic                   tick, wrap;
  logic                   w_ctrl, w_per, w_cnt, w_msk, w_clr;

  assign w_ctrl = wr_en && wr_addr == AW'(A_CTRL);
  assign w_per  = wr_en && wr_addr == AW'(A_PER);
  assign w_cnt  = wr_en && wr_addr == AW'(A_CNT);
  assign w_msk  = wr_en && wr_addr == AW'(A_MSK);
  assign w_clr  = wr_en && wr_addr == AW'(A_CLR);

  always_comb
    for (int k = 0; k < PRW; k++) pmask[k] = (k < int'(psel));

  assign tick = en && ((pre & pmask) == pmask);
  assign wrap = tick && (dir ? (cnt == '0) : (cnt == per_act));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; dir <= 1'b0; psel <= '0; ch_en <= '0; msk <= '0;
    end else begin
      if (w_ctrl) begin
        en    <= wr_data[0];
        dir   <= wr_data[1];
        psel  <= wr_data[2 +: PSW];
        ch_en <= wr_data[CH_LSB +: NCH];
      end
      if (w_msk) msk <= wr_data[NCH-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pre <= '0;
    else if (!en) pre <= '0;
    else          pre <= pre + PRW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_act <= '1; per_buf <= '1; per_bv <= 1'b0;
    end else if (w_per) begin
      per_buf <= wr_data;
      if (!en) begin
        per_act <= wr_data;
        per_bv  <= 1'b0;
      end else begin
        per_bv  <= 1'b1;
      end
    end else if (wrap && per_bv) begin
      per_act <= per_buf;
      per_bv  <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (w_cnt)   cnt <= wr_data;
    else if (tick) begin
      if (wrap)       cnt <= dir ? (per_bv ? per_buf : per_act) : '0;
      else if (dir)   cnt <= cnt - W'(1);
      else            cnt <= cnt + W'(1);
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic w_cmp;
    assign w_cmp = wr_en && wr_addr == AW'(A_CMP + i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmp_act[i] <= '0; cmp_buf[i] <= '0; cmp_bv[i] <= 1'b0;
      end else if (w_cmp) begin
        cmp_buf[i] <= wr_data;
        if (!en) begin
          cmp_act[i] <= wr_data;
          cmp_bv[i]  <= 1'b0;
        end else begin
          cmp_bv[i]  <= 1'b1;
        end
      end else if (wrap && cmp_bv[i]) begin
        cmp_act[i] <= cmp_buf[i];
        cmp_bv[i]  <= 1'b0;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flg[i] <= 1'b0;
      else        flg[i] <= (flg[i] && !(w_clr && wr_data[i])) || (tick && cnt == cmp_act[i]);

    assign pwm[i] = ch_en[i] && (cnt < cmp_act[i]);
  end

  assign irq   = |(flg & msk);
  assign flags = flg;
  assign count = cnt;
endmodule

// File: rtl/pwm4_timer_chk.sv
module pwm4_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [W-1:0]          wr_data,
  input logic [NCH-1:0]        pwm,
  input logic                  irq,
  input logic [NCH-1:0]        flags,
  input logic [W-1:0]          count,
  input logic                  en,
  input logic                  dir,
  input logic                  tick,
  input logic [W-1:0]          per_act,
  input logic [NCH-1:0][W-1:0] cmp_act
);
  logic cnt_wr, clr_wr;
  assign cnt_wr = wr_en && wr_addr == AW'(2);
  assign clr_wr = wr_en && wr_addr == AW'(4);

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir && !cnt_wr && count != per_act) |=> count == $past(count) + W'(1)); // R2
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dir && !cnt_wr && count == per_act) |=> count == '0); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir && !cnt_wr && count != '0) |=> count == $past(count) - W'(1)); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count)); // R4
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != '0); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_wr && wr_data[i])) |=> flags[i]); // R9
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act[i] == '0) |-> !pwm[i]); // R6
  end
endmodule

bind pwm4_timer pwm4_timer_chk #(.W(W), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm(pwm), .irq(irq), .flags(flags), .count(count), .en(en), .dir(dir),
  .tick(tick), .per_act(per_act), .cmp_act(cmp_act)
);

// File: tb/test_pwm4_timer.sv
module test_pwm4_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm, flags;
  logic        irq;
  logic [15:0] count;

  int total = 0, bad = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    logic [3:0]  sel;
    logic [15:0] c;
    logic [3:0]  p;
    logic [3:0]  f;
    logic        i;
  } exp_t;
  exp_t q[$];

  localparam logic [3:0] C = 4'b0001, P = 4'b0010, F = 4'b0100, I = 4'b1000, ALL = 4'b1111;

  pwm4_timer i_pwm4_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm(pwm), .irq(irq), .flags(flags), .count(count)
  );

  always #5 clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string r, input logic [3:0] s, input logic [15:0] c,
                            input logic [3:0] p, input logic [3:0] f, input logic i);
    exp_t e;
    e.req = r; e.sel = s; e.c = c; e.p = p; e.f = f; e.i = i;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if ((e.sel[0] && count !== e.c) || (e.sel[1] && pwm !== e.p) ||
          (e.sel[2] && flags !== e.f) || (e.sel[3] && irq !== e.i)) begin
        bad++;
        $display("FAIL %s: actual count=%0d pwm=%b flags=%b irq=%b expected count=%0d pwm=%b flags=%b irq=%b (fields %b)",
                 e.req, count, pwm, flags, irq, e.c, e.p, e.f, e.i, e.sel);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 reset state", ALL, 16'd0, 4'b0000, 4'b0000, 1'b0);
    rst_n = 1'b1;
    idle(1);
    expect_now("R1 after release", ALL, 16'd0, 4'b0000, 4'b0000, 1'b0);

    wr(4'd1, 16'd9);
    wr(4'd8, 16'd3);
    wr(4'd9, 16'd0);
    wr(4'd10, 16'd10);
    wr(4'd11, 16'd5);
    wr(4'd3, 16'h0001);
    wr(4'd0, 16'h0701);
    expect_now("R8 direct load while stopped, R6 duty", ALL, 16'd0, 4'b0101, 4'b0000, 1'b0);
    idle(1);
    expect_now("R2 step, R9 flag at zero compare, R6 zero duty", ALL, 16'd1, 4'b0101, 4'b0010, 1'b0);
    idle(3);
    expect_now("R10 masked flag raises irq", ALL, 16'd4, 4'b0100, 4'b0011, 1'b1);
    idle(2);
    expect_now("R9 disabled channel still flags", ALL, 16'd6, 4'b0100, 4'b1011, 1'b1);
    idle(4);
    expect_now("R2 wrap after P, R6 full duty", ALL, 16'd0, 4'b0101, 4'b1011, 1'b1);
    wr(4'd4, 16'h000B);
    expect_now("R9 set wins over clear", ALL, 16'd1, 4'b0101, 4'b0010, 1'b0);

    wr(4'd8, 16'd7);
    wr(4'd1, 16'd4);
    idle(2);
    expect_now("R7 compare buffered until wrap", ALL, 16'd5, 4'b0100, 4'b0011, 1'b1);
    idle(5);
    expect_now("R7 old period at wrap", ALL, 16'd0, 4'b0101, 4'b1011, 1'b1);
    idle(4);
    expect_now("R7 new compare after wrap", C | P, 16'd4, 4'b0101, 4'b0000, 1'b0);
    idle(1);
    expect_now("R7 new period after wrap", C, 16'd0, 4'b0000, 4'b0000, 1'b0);
    wr(4'd4, 16'h000F);
    expect_now("R9 clear with re-set", ALL, 16'd1, 4'b0101, 4'b0010, 1'b0);

    wr(4'd2, 16'd3);
    expect_now("R11 counter load", ALL, 16'd3, 4'b0101, 4'b0010, 1'b0);
    wr(4'd0, 16'h0700);
    idle(3);
    expect_now("R4 hold while stopped", C | P, 16'd4, 4'b0101, 4'b0000, 1'b0);
    wr(4'd8, 16'd2);
    expect_now("R8 compare direct while stopped", C | P, 16'd4, 4'b0100, 4'b0000, 1'b0);

    wr(4'd4, 16'h000F);
    wr(4'd2, 16'd0);
    wr(4'd0, 16'h0703);
    expect_now("R3 start down", ALL, 16'd0, 4'b0101, 4'b0000, 1'b0);
    idle(1);
    expect_now("R3 wrap 0 to P", ALL, 16'd4, 4'b0100, 4'b0010, 1'b0);
    idle(2);
    expect_now("R3 decrement", ALL, 16'd2, 4'b0100, 4'b0010, 1'b0);
    idle(1);
    expect_now("R3 down duty, R9 match", ALL, 16'd1, 4'b0101, 4'b0011, 1'b1);
    wr(4'd8, 16'd4);
    expect_now("R7 down compare buffered", C | P, 16'd0, 4'b0101, 4'b0000, 1'b0);
    idle(1);
    expect_now("R7 down load at zero", C | P, 16'd4, 4'b0100, 4'b0000, 1'b0);
    idle(1);
    expect_now("R7 down new compare", C | P, 16'd3, 4'b0101, 4'b0000, 1'b0);

    wr(4'd0, 16'h0702);
    wr(4'd2, 16'd0);
    wr(4'd0, 16'h0709);
    idle(3);
    expect_now("R5 divide by 4 waits", C, 16'd0, 4'b0000, 4'b0000, 1'b0);
    idle(1);
    expect_now("R5 first advance", C, 16'd1, 4'b0000, 4'b0000, 1'b0);
    idle(4);
    expect_now("R5 second advance", C, 16'd2, 4'b0000, 4'b0000, 1'b0);

    wr(4'd3, 16'h0000);
    expect_now("R10 all masked", I, 16'd0, 4'b0000, 4'b0000, 1'b0);
    wr(4'd3, 16'h0002);
    expect_now("R10 flag1 unmasked", I, 16'd0, 4'b0000, 4'b0000, 1'b1);

    idle(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule